// File: doc/BRIEF.md
# Masked Event-Latching Interrupt Controller

This block collects up to 64 single-cycle event pulses from on-chip sources and turns them into one level interrupt for a host processor. The sources are grouped into a low half (event input bits 31:0) and a high half (bits 63:32). Each half has its own mask register, its own event register and its own acknowledge register. All of them sit behind a small synchronous register bus with an address, a write enable, write data and combinational read data.

A mask bit works at the point of capture. When the bit is 0, a pulse on that source sets the matching event bit. When the bit is 1, the pulse is dropped and leaves no trace in the event register. Both masks come out of reset as all ones, so software must enable each source before any event can be recorded. After servicing, software clears the recorded bits by writing ones to the write-only acknowledge register of that half. The interrupt output stays high while any recorded bit in either half is set.

The block has no sequencing of its own. Its behaviour is a per-bit set/clear rule evaluated every clock, plus address decoding, so it has no enumerated states or transitions.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset, the mask registers at 0x10 and 0x14 read 0xFFFFFFFF, the event registers at 0x18 and 0x1C read 0, and `irq_o` is low.
- R2: The mask registers can be written and read back. Offset 0x10 masks `evt_i[31:0]` and offset 0x14 masks `evt_i[63:32]`. A write takes effect at the clock edge where `bus_we` is high.
- R3: When a mask bit is 1, a pulse on the matching event input does not set the event bit.
- R4: When a mask bit is 0, a pulse on the matching input is sampled at a clock edge and sets the event bit from that edge on. The low event register reads at 0x18 and the high event register reads at 0x1C, with bit positions matching `evt_i`.
- R5: A captured event bit stays set after its pulse ends. Capturing a new event does not change any other event bit.
- R6: Writing to the acknowledge registers (0x20 for the low half, 0x24 for the high half) clears each event bit whose write-data bit is 1 and leaves the bits written with 0 unchanged.
- R7: If a capturable pulse and an acknowledge of the same bit occur at the same clock edge, the bit ends up set.
- R8: Changing a mask bit from 0 to 1 does not clear an event bit that is already captured. Only an acknowledge clears it.
- R9: `irq_o` is high exactly when at least one event bit in either half is set. It rises in the cycle after a capture.
- R10: Reads of the acknowledge offsets and of unmapped offsets return 0. Writes to the event register offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| evt_i | input | 64 | Event pulses; bits 31:0 form the low half, 63:32 the high half |
| irq_o | output | 1 | Active-high level interrupt |

## Verification
The capture rule is first driven with all 64 sources pulsing at once. This is done with masks at reset value, all zero, alternating bit patterns and half-word patterns, which separates per-bit masking from whole-register behaviour and from swapped halves. A walking single source is then swept over all 64 positions while its neighbour is also captured, and each bit is acknowledged on its own. This exposes wrong bit order, wrong half routing, acknowledges that clear too much, and captures that overwrite older bits. Directed cases then place a pulse and an acknowledge of the same bit on one edge, raise a mask over an already captured bit, and access the acknowledge, unmapped and read-only offsets. These cases separate set-priority, mask-at-capture and decode faults.

// File: rtl/irq_pkg.sv
package irq_pkg;
    // Register offsets; each group holds one word per half, 4 bytes apart
    localparam int MASK_BASE  = 'h10;
    localparam int EVT_BASE   = 'h18;
    localparam int ACK_BASE   = 'h20;
    localparam int WORD_BYTES = 4;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_MASK,
        KIND_EVT,
        KIND_ACK
    } reg_kind_e;
endpackage

// File: rtl/irq_ev_half.sv
module irq_ev_half #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_we,
    input  logic         ack_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pulse,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] evt_q,
    output logic         any_o
);
    logic [W-1:0] clr_bits;
    logic [W-1:0] set_bits;
    logic [W-1:0] evt_d;

    always_comb begin
        clr_bits = ack_we ? wdata : '0;
        set_bits = pulse & ~mask_q;
        // a capture in the same edge overrides the clear
        evt_d    = (evt_q & ~clr_bits) | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            evt_q  <= '0;
        end else begin
            if (mask_we) begin
                mask_q <= wdata;
            end
            evt_q <= evt_d;
        end
    end

    assign any_o = |evt_q;

    AST_NO_MASKED_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_q & ~$past(evt_q) & ~$past(pulse & ~mask_q)) == '0)); // R3
    AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pulse & ~mask_q) & ~evt_q) == '0)); // R7
    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(evt_q) & ~$past(clr_bits) & ~evt_q) == '0)); // R8
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(clr_bits & ~(pulse & ~mask_q)) & evt_q) == '0)); // R6
endmodule

// File: rtl/irq_regdec.sv
module irq_regdec
    import irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int W      = 32,
    parameter int NH     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [NH*W-1:0]   mask_all,
    input  logic [NH*W-1:0]   evt_all,
    output logic [NH-1:0]     mask_we,
    output logic [NH-1:0]     ack_we,
    output logic [W-1:0]      rdata
);
    reg_kind_e    kind [NH];
    logic [W-1:0] part [NH];

    for (genvar h = 0; h < NH; h++) begin : g_dec
        localparam logic [ADDR_W-1:0] MASK_OFF = ADDR_W'(MASK_BASE + WORD_BYTES * h);
        localparam logic [ADDR_W-1:0] EVT_OFF  = ADDR_W'(EVT_BASE + WORD_BYTES * h);
        localparam logic [ADDR_W-1:0] ACK_OFF  = ADDR_W'(ACK_BASE + WORD_BYTES * h);

        always_comb begin
            if (addr == MASK_OFF)      kind[h] = KIND_MASK;
            else if (addr == EVT_OFF)  kind[h] = KIND_EVT;
            else if (addr == ACK_OFF)  kind[h] = KIND_ACK;
            else                       kind[h] = KIND_NONE;
        end

        always_comb begin
            unique case (kind[h])
                KIND_MASK: part[h] = mask_all[h*W +: W];
                KIND_EVT:  part[h] = evt_all[h*W +: W];
                default:   part[h] = '0;
            endcase
        end

        assign mask_we[h] = we && (kind[h] == KIND_MASK);
        assign ack_we[h]  = we && (kind[h] == KIND_ACK);

        AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (addr == ACK_OFF) |-> (rdata == '0)); // R10
    end

    always_comb begin
        rdata = '0;
        for (int h = 0; h < NH; h++) begin
            rdata = rdata | part[h];
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mask_we, ack_we})); // R2
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl #(
    parameter int ADDR_W = 8,
    parameter int HALF_W = 32,
    parameter int NUM_HALVES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_we,
    input  logic [HALF_W-1:0]            bus_wdata,
    output logic [HALF_W-1:0]            bus_rdata,
    input  logic [NUM_HALVES*HALF_W-1:0] evt_i,
    output logic                         irq_o
);
    localparam int TOTAL = NUM_HALVES * HALF_W;

    logic [NUM_HALVES-1:0] mask_we;
    logic [NUM_HALVES-1:0] ack_we;
    logic [NUM_HALVES-1:0] any_h;
    logic [TOTAL-1:0]      mask_all;
    logic [TOTAL-1:0]      evt_all;

    irq_regdec #(
        .ADDR_W(ADDR_W),
        .W     (HALF_W),
        .NH    (NUM_HALVES)
    ) dec_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .we      (bus_we),
        .mask_all(mask_all),
        .evt_all (evt_all),
        .mask_we (mask_we),
        .ack_we  (ack_we),
        .rdata   (bus_rdata)
    );

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        irq_ev_half #(.W(HALF_W)) half_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .mask_we(mask_we[h]),
            .ack_we (ack_we[h]),
            .wdata  (bus_wdata),
            .pulse  (evt_i[h*HALF_W +: HALF_W]),
            .mask_q (mask_all[h*HALF_W +: HALF_W]),
            .evt_q  (evt_all[h*HALF_W +: HALF_W]),
            .any_o  (any_h[h])
        );
    end

    assign irq_o = |any_h;

    AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(|evt_i)); // R9
endmodule

// File: tb/irq_latch_ctrl_tb.sv
module irq_latch_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] evt_i = '0;
    logic        irq_o;

    int checks = 0;
    int fails = 0;
    logic [63:0] m_mask = '1;
    logic [63:0] m_evt = '0;

    always #5 clk = ~clk;

    irq_latch_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // one clock edge with given bus and event inputs; model updated in step
    task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d, input logic [63:0] ev);
        logic [63:0] ack;
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d; evt_i = ev;
        ack = '0;
        if (we && a == 8'h20) ack[31:0] = d;
        if (we && a == 8'h24) ack[63:32] = d;
        m_evt = (m_evt & ~ack) | (ev & ~m_mask);
        if (we && a == 8'h10) m_mask[31:0] = d;
        if (we && a == 8'h14) m_mask[63:32] = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; evt_i = '0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic check_all(input string req);
        rd({req, " mask lo"}, 8'h10, m_mask[31:0]);
        rd({req, " mask hi"}, 8'h14, m_mask[63:32]);
        rd({req, " evt lo"}, 8'h18, m_evt[31:0]);
        rd({req, " evt hi"}, 8'h1C, m_evt[63:32]);
        chk({req, " irq R9"}, {31'b0, irq_o}, {31'b0, |m_evt});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'h0; pats[1] = 32'hFFFFFFFF; pats[2] = 32'hA5A5A5A5; pats[3] = 32'h0000FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        // R3: all masked, every source pulses
        step(1'b0, 8'h00, '0, '1);
        check_all("R3 masked");

        // R2/R4/R6: mask patterns per half
        for (int h = 0; h < 2; h++) begin
            for (int p = 0; p < 4; p++) begin
                step(1'b1, 8'(8'h10 + 4 * h), pats[p], '0);
                step(1'b0, 8'h00, '0, '1);
                check_all("R2 R4 pattern");
                step(1'b1, 8'h20, 32'hFFFFFFFF, '0);
                step(1'b1, 8'h24, 32'hFFFFFFFF, '0);
                check_all("R6 ack all");
            end
            step(1'b1, 8'(8'h10 + 4 * h), 32'hFFFFFFFF, '0);
        end

        // R4/R5/R6: walking source with neighbour
        step(1'b1, 8'h10, 32'h0, '0);
        step(1'b1, 8'h14, 32'h0, '0);
        for (int i = 0; i < 64; i++) begin
            int j;
            logic [63:0] b;
            j = (i + 1) % 64;
            step(1'b0, 8'h00, '0, 64'd1 << i);
            check_all("R4 walk");
            step(1'b0, 8'h00, '0, 64'd1 << j);
            check_all("R5 neighbour kept");
            b = 64'd1 << i;
            step(1'b1, (i < 32) ? 8'h20 : 8'h24, (i < 32) ? b[31:0] : b[63:32], '0);
            check_all("R6 single ack");
            b = 64'd1 << j;
            step(1'b1, (j < 32) ? 8'h20 : 8'h24, (j < 32) ? b[31:0] : b[63:32], '0);
            check_all("R6 second ack");
        end

        // R7: pulse and ack of same bits on one edge
        step(1'b1, 8'h20, 32'h0000_0F0F, 64'h0000_0001_0000_0F00);
        check_all("R7 capture wins");
        rd("R7 lo", 8'h18, 32'h0000_0F00);

        // R8: raise mask over captured bits
        step(1'b1, 8'h14, 32'hFFFFFFFF, '0);
        step(1'b1, 8'h10, 32'hFFFFFFFF, '0);
        check_all("R8 mask raise");
        rd("R8 hi kept", 8'h1C, 32'h1);

        // R10: ack/unmapped reads zero, event regs ignore writes
        rd("R10 ack lo read", 8'h20, 32'h0);
        rd("R10 ack hi read", 8'h24, 32'h0);
        rd("R10 unmapped", 8'h00, 32'h0);
        rd("R10 unmapped hi", 8'h3C, 32'h0);
        step(1'b1, 8'h18, 32'h0, '0);
        step(1'b1, 8'h1C, 32'hFFFF_FFFF, '0);
        check_all("R10 evt write ignored");

        step(1'b1, 8'h20, 32'hFFFFFFFF, '0);
        step(1'b1, 8'h24, 32'hFFFFFFFF, '0);
        check_all("R6 R9 final clear");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule